// File: doc/BRIEF.md
# Core Supply Sequencing Controller

This block lives in the always-on domain and brings the core domain up in a fixed order. After the always-on power-on reset is released, it waits for the low-frequency RC oscillator to report that it is stable. It then turns on the core regulator, waits for the core-voltage-valid indication, and only then releases the active-low core reset.

While the core runs, two optional detectors supervise it: a monitor of the always-on supply and a core brownout detector. Software enables each one separately. When an enabled detector reports an undervoltage, the core goes back into reset and stays there until the flag clears. After that, core voltage is checked again before the reset is released. A sticky field records which detector caused the most recent reset.

The block also chooses the slow clock. It starts on the RC oscillator. Software can start the crystal oscillator and request a switch to it. The switch happens only after a programmable number of crystal cycles has passed, it is glitch-free, and it cannot be undone until the next power-on reset. All analog status flags are asynchronous and pass through two-flop synchronizers before they are used.

Top module: `core_supply_seq`

## Requirements
- R1: While `por_n` is low: `reg_en`=0, `core_rst_n`=0, `xtal_osc_en`=0 and `status`=0.
- R2: While `rc_ready` is low after POR release, the sequencer stays in state code 0 with `reg_en`=0, whatever `vcore_ok` is.
- R3: Once `rc_ready` is high, state becomes 1 and `reg_en`=1. `core_rst_n` stays 0 for as long as `vcore_ok` is low.
- R4: In state 1, a high `vcore_ok` moves the sequencer to state 2 (run), with `core_rst_n`=1 and `reg_en` kept at 1.
- R5: In run, if the always-on monitor is enabled (control register, address 0, bit 0) and `aon_low` is high, the sequencer enters state 3 and sets `core_rst_n`=0 and cause field `status[5:4]`=01. It holds there until `aon_low` falls, then goes through state 1 back to run.
- R6: In run, if brownout detection is enabled (address 0, bit 1) and `core_low` is high, the sequencer enters state 4 and sets `core_rst_n`=0 and cause `status[5:4]`=10. It holds there until `core_low` falls, then goes through state 1 back to run.
- R7: Both detector enables are 0 after POR. The flag of a disabled detector has no effect on `core_rst_n` or the state.
- R8: If both enabled detectors flag at the same time, the always-on monitor wins (state 3, cause 01).
- R9: The cause field keeps its value after the core reset is released, until a later detector event overwrites it or POR clears it.
- R10: After POR the slow clock runs from `clk` (the RC oscillator) and `status[3]`=0. A select request (address 0, bit 3) is ignored unless crystal enable (bit 2) is set in the same write or was already set.
- R11: `xtal_osc_en` follows the crystal enable. The switch to the crystal happens only after the crystal has run for at least the count written at address 1.
- R12: Once switched, `slow_clk` runs from `xtal_clk` and `status[3]`=1 until POR, whatever is written later. The two clock sources are never gated on together.
- R13: A change on `rc_ready`, `vcore_ok`, `aon_low` or `core_low` reaches the outputs after the third rising `clk` edge that follows it, and never earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | RC oscillator clock, clocks the controller |
| xtal_clk | input | 1 | Crystal oscillator clock |
| por_n | input | 1 | Always-on power-on reset, active low, asynchronous |
| rc_ready | input | 1 | RC oscillator stable flag |
| vcore_ok | input | 1 | Core voltage valid flag |
| aon_low | input | 1 | Always-on supply too low flag |
| core_low | input | 1 | Core brownout flag |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | 0: control bits, 1: crystal start-up count |
| wr_data | input | DW | Write data |
| reg_en | output | 1 | Core regulator enable |
| core_rst_n | output | 1 | Core reset, active low |
| xtal_osc_en | output | 1 | Crystal oscillator enable |
| slow_clk | output | 1 | Selected slow clock |
| status | output | 8 | [2:0] state, [3] crystal selected, [5:4] last reset cause, [7:6] zero |

## Verification
A wrong sequencer state shows up on `reg_en`, `core_rst_n` and `status[2:0]` at the third clock edge after the status input that should have moved it. A state that fails to leave a hold appears as a core reset that stays low after the flag has dropped. If the cause register loses its value, the cause field is wrong once the core is running again. A fault in the clock-switch logic shows in the edge rate of `slow_clk`, measured over a window shortly after the programmed start-up count has elapsed. A premature switch shows as `status[3]` set while the crystal is still counting.

// File: rtl/csq_pkg.sv
`timescale 1ns/1ps
package csq_pkg;
    typedef enum logic [2:0] {
        ST_WAIT     = 3'd0,
        ST_REG_ON   = 3'd1,
        ST_RUN      = 3'd2,
        ST_HOLD_AON = 3'd3,
        ST_HOLD_BOD = 3'd4
    } seq_state_e;

    typedef enum logic [1:0] {
        CAUSE_NONE = 2'b00,
        CAUSE_AON  = 2'b01,
        CAUSE_BOD  = 2'b10
    } cause_e;

    localparam int unsigned CTL_AON_BIT  = 0;
    localparam int unsigned CTL_BOD_BIT  = 1;
    localparam int unsigned CTL_XEN_BIT  = 2;
    localparam int unsigned CTL_XSEL_BIT = 3;

    typedef struct packed {
        seq_state_e state;
        cause_e     cause;
    } seq_regs_t;
endpackage

// File: rtl/csq_sync.sv
`timescale 1ns/1ps
module csq_sync #(
    parameter int unsigned W = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta_q, hold_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= '0;
            hold_q <= '0;
        end else begin
            meta_q <= d;
            hold_q <= meta_q;
        end
    end

    assign q = hold_q;
endmodule

// File: rtl/csq_seq_fsm.sv
`timescale 1ns/1ps
module csq_seq_fsm
    import csq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rc_ready_s,
    input  logic       vcore_ok_s,
    input  logic       aon_low_s,
    input  logic       core_low_s,
    input  logic       aon_mon_en,
    input  logic       core_bod_en,
    output logic       reg_en,
    output logic       core_rst_n,
    output logic [2:0] state_o,
    output logic [1:0] cause_o
);
    seq_regs_t seq_d, seq_q;

    always_comb begin
        seq_d = seq_q;
        unique case (seq_q.state)
            ST_WAIT: begin
                if (rc_ready_s) seq_d.state = ST_REG_ON;
            end
            ST_REG_ON: begin
                if (vcore_ok_s) seq_d.state = ST_RUN;
            end
            ST_RUN: begin
                if (aon_mon_en && aon_low_s) begin
                    seq_d.state = ST_HOLD_AON;
                    seq_d.cause = CAUSE_AON;
                end else if (core_bod_en && core_low_s) begin
                    seq_d.state = ST_HOLD_BOD;
                    seq_d.cause = CAUSE_BOD;
                end
            end
            ST_HOLD_AON: begin
                if (!aon_low_s) seq_d.state = ST_REG_ON;
            end
            ST_HOLD_BOD: begin
                if (!core_low_s) seq_d.state = ST_REG_ON;
            end
            default: seq_d.state = ST_WAIT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q.state <= ST_WAIT;
            seq_q.cause <= CAUSE_NONE;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign reg_en     = (seq_q.state != ST_WAIT);
    assign core_rst_n = (seq_q.state == ST_RUN);
    assign state_o    = seq_q.state;
    assign cause_o    = seq_q.cause;

    // R4: the core reset is released only after a synchronized valid core voltage
    p_release_needs_vcore_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(core_rst_n) |-> $past(vcore_ok_s));

    // R2 / R3: from the wait state the only way out is regulator start
    p_wait_exit_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.state == ST_WAIT) |=> (seq_q.state == ST_WAIT || seq_q.state == ST_REG_ON));

    p_aon_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.state == ST_HOLD_AON && aon_low_s) |=> (seq_q.state == ST_HOLD_AON && !core_rst_n));

    p_bod_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.state == ST_HOLD_BOD && core_low_s) |=> (seq_q.state == ST_HOLD_BOD && !core_rst_n));

    p_disabled_ignored_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.state == ST_RUN && !aon_mon_en && !core_bod_en) |=> core_rst_n);

    p_cause_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.state != ST_RUN) |=> $stable(cause_o));
endmodule

// File: rtl/csq_clk_switch.sv
`timescale 1ns/1ps
module csq_clk_switch #(
    parameter int unsigned CW = 16
) (
    input  logic          clk,
    input  logic          xtal_clk,
    input  logic          rst_n,
    input  logic          xtal_en,
    input  logic          sel_req,
    input  logic [CW-1:0] start_cnt,
    output logic          slow_clk,
    output logic          xtal_selected
);
    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          rdy;
    } xt_regs_t;

    xt_regs_t xt_d, xt_q;
    logic en_x, rdy_c, rc_off_x;
    logic rc_on_d, rc_on_q, xt_on_d, xt_on_q;

    csq_sync #(.W(1)) u_en_sync (
        .clk(xtal_clk), .rst_n(rst_n), .d(xtal_en), .q(en_x)
    );

    always_comb begin
        xt_d = xt_q;
        if (!en_x) begin
            xt_d.cnt = '0;
            xt_d.rdy = 1'b0;
        end else if (!xt_q.rdy) begin
            if (xt_q.cnt >= start_cnt) xt_d.rdy = 1'b1;
            else                       xt_d.cnt = xt_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge xtal_clk or negedge rst_n) begin
        if (!rst_n) xt_q <= '0;
        else        xt_q <= xt_d;
    end

    csq_sync #(.W(1)) u_rdy_sync (
        .clk(clk), .rst_n(rst_n), .d(xt_q.rdy), .q(rdy_c)
    );

    // RC gate: changes on the falling edge of clk, only ever turns off
    always_comb rc_on_d = rc_on_q & ~(sel_req & rdy_c);

    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) rc_on_q <= 1'b1;
        else        rc_on_q <= rc_on_d;
    end

    csq_sync #(.W(1)) u_off_sync (
        .clk(xtal_clk), .rst_n(rst_n), .d(~rc_on_q), .q(rc_off_x)
    );

    // Crystal gate: opens on a falling crystal edge after the RC gate closed
    always_comb xt_on_d = xt_on_q | rc_off_x;

    always_ff @(negedge xtal_clk or negedge rst_n) begin
        if (!rst_n) xt_on_q <= 1'b0;
        else        xt_on_q <= xt_on_d;
    end

    assign slow_clk      = (clk & rc_on_q) | (xtal_clk & xt_on_q);
    assign xtal_selected = ~rc_on_q;

    p_one_source_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !(rc_on_q && xt_on_q));

    p_rc_stays_off_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !rc_on_q |=> !rc_on_q);

    p_switch_after_count_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rc_on_q) |-> rdy_c);
endmodule

// File: rtl/core_supply_seq.sv
`timescale 1ns/1ps
module core_supply_seq
    import csq_pkg::*;
#(
    parameter int unsigned DW          = 16,
    parameter int unsigned CW          = 16,
    parameter int unsigned XT_CNT_INIT = 512
) (
    input  logic          clk,
    input  logic          xtal_clk,
    input  logic          por_n,
    input  logic          rc_ready,
    input  logic          vcore_ok,
    input  logic          aon_low,
    input  logic          core_low,
    input  logic          wr_en,
    input  logic          wr_addr,
    input  logic [DW-1:0] wr_data,
    output logic          reg_en,
    output logic          core_rst_n,
    output logic          xtal_osc_en,
    output logic          slow_clk,
    output logic [7:0]    status
);
    localparam int unsigned NSTAT = 4;
    localparam logic [CW-1:0] CNT_RST = CW'(XT_CNT_INIT);

    typedef struct packed {
        logic          aon_mon_en;
        logic          core_bod_en;
        logic          xtal_en;
        logic          xtal_sel;
        logic [CW-1:0] start_cnt;
    } ctl_regs_t;

    ctl_regs_t ctl_d, ctl_q;
    logic [NSTAT-1:0] raw_flags, sync_flags;
    logic [2:0] state_w;
    logic [1:0] cause_w;
    logic       xtal_act;

    always_comb begin
        ctl_d = ctl_q;
        if (wr_en) begin
            if (!wr_addr) begin
                ctl_d.aon_mon_en  = wr_data[CTL_AON_BIT];
                ctl_d.core_bod_en = wr_data[CTL_BOD_BIT];
                ctl_d.xtal_en     = wr_data[CTL_XEN_BIT];
                if (wr_data[CTL_XSEL_BIT] && (wr_data[CTL_XEN_BIT] || ctl_q.xtal_en))
                    ctl_d.xtal_sel = 1'b1;
            end else begin
                ctl_d.start_cnt = wr_data[CW-1:0];
            end
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            ctl_q.aon_mon_en  <= 1'b0;
            ctl_q.core_bod_en <= 1'b0;
            ctl_q.xtal_en     <= 1'b0;
            ctl_q.xtal_sel    <= 1'b0;
            ctl_q.start_cnt   <= CNT_RST;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign raw_flags = {core_low, aon_low, vcore_ok, rc_ready};

    csq_sync #(.W(NSTAT)) u_stat_sync (
        .clk(clk), .rst_n(por_n), .d(raw_flags), .q(sync_flags)
    );

    csq_seq_fsm u_fsm (
        .clk         (clk),
        .rst_n       (por_n),
        .rc_ready_s  (sync_flags[0]),
        .vcore_ok_s  (sync_flags[1]),
        .aon_low_s   (sync_flags[2]),
        .core_low_s  (sync_flags[3]),
        .aon_mon_en  (ctl_q.aon_mon_en),
        .core_bod_en (ctl_q.core_bod_en),
        .reg_en      (reg_en),
        .core_rst_n  (core_rst_n),
        .state_o     (state_w),
        .cause_o     (cause_w)
    );

    assign xtal_osc_en = ctl_q.xtal_en | ctl_q.xtal_sel;

    csq_clk_switch #(.CW(CW)) u_clk_sw (
        .clk           (clk),
        .xtal_clk      (xtal_clk),
        .rst_n         (por_n),
        .xtal_en       (xtal_osc_en),
        .sel_req       (ctl_q.xtal_sel),
        .start_cnt     (ctl_q.start_cnt),
        .slow_clk      (slow_clk),
        .xtal_selected (xtal_act)
    );

    assign status = {2'b00, cause_w, xtal_act, state_w};

    p_sel_sticky_r12: assert property (@(posedge clk) disable iff (!por_n)
        status[3] |=> status[3]);

    p_sel_needs_osc_r10: assert property (@(posedge clk) disable iff (!por_n)
        status[3] |-> xtal_osc_en);

    p_regen_with_run_r4: assert property (@(posedge clk) disable iff (!por_n)
        core_rst_n |-> reg_en);
endmodule

// File: tb/tb_core_supply_seq.sv
`timescale 1ns/1ps
module tb_core_supply_seq;
    localparam int unsigned DW = 16;

    logic clk = 1'b0, xtal_clk = 1'b0;
    logic por_n = 1'b0, rc_ready = 1'b0, vcore_ok = 1'b0, aon_low = 1'b0, core_low = 1'b0;
    logic wr_en = 1'b0, wr_addr = 1'b0;
    logic [DW-1:0] wr_data = '0;
    logic reg_en, core_rst_n, xtal_osc_en, slow_clk;
    logic [7:0] status;

    int n_chk = 0, n_err = 0;
    bit done = 1'b0;
    bit cnt_on = 1'b0;
    int sc_cnt = 0;

    always #10 clk = ~clk;
    always #7  xtal_clk = ~xtal_clk;

    always @(posedge slow_clk) if (cnt_on) sc_cnt++;

    core_supply_seq #(.DW(DW), .CW(16), .XT_CNT_INIT(512)) dut (
        .clk(clk), .xtal_clk(xtal_clk), .por_n(por_n), .rc_ready(rc_ready),
        .vcore_ok(vcore_ok), .aon_low(aon_low), .core_low(core_low),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .reg_en(reg_en), .core_rst_n(core_rst_n), .xtal_osc_en(xtal_osc_en),
        .slow_clk(slow_clk), .status(status)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic chk_range(input string req, input int act, input int lo, input int hi);
        n_chk++;
        if (act < lo || act > hi) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d..%0d", req, act, lo, hi);
        end
    endtask

    task automatic wr(input bit addr, input logic [DW-1:0] data);
        wr_en = 1'b1; wr_addr = addr; wr_data = data;
        tick(1);
        wr_en = 1'b0; wr_data = '0;
    endtask

    // expected state code after flags have settled (R5, R6, R8)
    function automatic int exp_state(input bit aon_en, input bit bod_en, input bit a, input bit b);
        if (aon_en && a) return 3;
        if (bod_en && b) return 4;
        return 2;
    endfunction

    function automatic int exp_cause(input int prev, input bit aon_en, input bit bod_en, input bit a, input bit b);
        if (aon_en && a) return 1;
        if (bod_en && b) return 2;
        return prev;
    endfunction

    task automatic measure(output int edges);
        sc_cnt = 0;
        cnt_on = 1'b1;
        #700;
        cnt_on = 1'b0;
        edges = sc_cnt;
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            n_err++; n_chk++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        int cause_m;
        int edges;
        void'($urandom(32'd20240611));
        vcore_ok = 1'b1;
        tick(3);
        // R1 reset state
        chk("R1 reg_en", reg_en, 0);
        chk("R1 core_rst_n", core_rst_n, 0);
        chk("R1 xtal_osc_en", xtal_osc_en, 0);
        chk("R1 status", status, 0);
        por_n = 1'b1;
        tick(6);
        // R2: no RC ready, core voltage high does not matter
        chk("R2 reg_en", reg_en, 0);
        chk("R2 state", status[2:0], 0);
        vcore_ok = 1'b0;
        tick(4);
        rc_ready = 1'b1;
        tick(2);
        chk("R13 reg_en early", reg_en, 0);
        tick(1);
        chk("R3 R13 reg_en", reg_en, 1);
        tick(5);
        chk("R3 state", status[2:0], 1);
        chk("R3 core_rst_n", core_rst_n, 0);
        vcore_ok = 1'b1;
        tick(2);
        chk("R13 core_rst_n early", core_rst_n, 0);
        tick(1);
        chk("R4 R13 core_rst_n", core_rst_n, 1);
        chk("R4 state", status[2:0], 2);
        chk("R4 reg_en", reg_en, 1);
        chk("R10 slow clock source", status[3], 0);

        // R7: detectors disabled after POR
        aon_low = 1'b1; core_low = 1'b1;
        tick(6);
        chk("R7 core_rst_n", core_rst_n, 1);
        chk("R7 state", status[2:0], 2);
        aon_low = 1'b0; core_low = 1'b0;
        tick(4);

        // R5 directed
        wr(1'b0, 16'h0001);
        tick(2);
        aon_low = 1'b1;
        tick(6);
        chk("R5 state", status[2:0], 3);
        chk("R5 core_rst_n", core_rst_n, 0);
        chk("R5 cause", status[5:4], 1);
        tick(20);
        chk("R5 held", core_rst_n, 0);
        aon_low = 1'b0;
        tick(6);
        chk("R5 release", core_rst_n, 1);
        chk("R9 cause kept", status[5:4], 1);

        // R6 directed
        wr(1'b0, 16'h0002);
        tick(2);
        core_low = 1'b1;
        tick(6);
        chk("R6 state", status[2:0], 4);
        chk("R6 cause", status[5:4], 2);
        chk("R6 core_rst_n", core_rst_n, 0);
        core_low = 1'b0;
        tick(6);
        chk("R6 release", core_rst_n, 1);
        chk("R9 cause kept", status[5:4], 2);

        // R8 priority
        wr(1'b0, 16'h0003);
        tick(2);
        aon_low = 1'b1; core_low = 1'b1;
        tick(6);
        chk("R8 state", status[2:0], 3);
        chk("R8 cause", status[5:4], 1);
        aon_low = 1'b0; core_low = 1'b0;
        tick(6);
        chk("R8 release", core_rst_n, 1);
        cause_m = 1;

        // random episodes
        for (int i = 0; i < 24; i++) begin
            bit ae, be, a, b;
            int es;
            ae = 1'($urandom); be = 1'($urandom);
            a  = 1'($urandom); b  = 1'($urandom);
            wr(1'b0, {14'd0, be, ae});
            tick(2);
            aon_low = a; core_low = b;
            tick(6);
            es = exp_state(ae, be, a, b);
            cause_m = exp_cause(cause_m, ae, be, a, b);
            chk("R5 R6 R7 R8 random state", status[2:0], es);
            chk("R5 R6 R7 random reset", core_rst_n, (es == 2) ? 1 : 0);
            chk("R9 random cause", status[5:4], cause_m);
            aon_low = 1'b0; core_low = 1'b0;
            tick(6);
            chk("R5 R6 random release", core_rst_n, 1);
        end

        // R10: select without crystal enable is ignored
        wr(1'b0, 16'h0008);
        tick(60);
        chk("R10 select ignored", status[3], 0);
        chk("R10 osc stays off", xtal_osc_en, 0);
        tick(1);
        measure(edges);
        chk_range("R10 slow clock from RC", edges, 33, 37);

        // R11: stabilization count
        tick(1);
        wr(1'b1, 16'd40);
        wr(1'b0, 16'h000C);
        tick(10);
        chk("R11 osc enabled", xtal_osc_en, 1);
        chk("R11 no early switch", status[3], 0);
        tick(60);
        chk("R11 switched", status[3], 1);
        tick(1);
        measure(edges);
        chk_range("R12 slow clock from crystal", edges, 48, 52);

        // R12: later writes cannot undo the switch
        tick(1);
        wr(1'b0, 16'h0000);
        tick(30);
        chk("R12 sticky source", status[3], 1);
        chk("R12 osc kept", xtal_osc_en, 1);
        tick(1);
        measure(edges);
        chk_range("R12 still crystal", edges, 48, 52);

        // R1 again: POR returns everything to reset
        tick(1);
        por_n = 1'b0;
        tick(2);
        chk("R1 re-POR status", status, 0);
        chk("R1 re-POR core_rst_n", core_rst_n, 0);
        chk("R1 re-POR xtal_osc_en", xtal_osc_en, 0);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end
endmodule